// File: doc/BRIEF.md
# Smart-Card Serial Flag and Interrupt Controller

This block sits between a processor bus and the bit-level engine of a smart-card style serial port. It holds the control enables, a transmit data register and a receive data register, each one byte deep, in front of the shifters. It also keeps the status flags and derives three interrupt requests: transmit-empty, receive-full and error. The shifters, baud generation and character framing live elsewhere. The engine side sees a load strobe toward the transmit shifter, a capture strobe from the receive shifter, and single-cycle error strobes for parity, card error signal and wait-time violations.

Two small state machines carry the data paths.

The transmit machine has three states:
- `TX_OFF`: transmission is disabled.
- `TX_EMPTY`: the register is free.
- `TX_HELD`: a byte waits for the shifter.

Its transitions are:
- `TX_OFF`→`TX_EMPTY`: enable set, no write in the same cycle.
- `TX_OFF`→`TX_HELD`: enable set and a data write in the same cycle.
- `TX_EMPTY`→`TX_HELD`: data write.
- `TX_HELD`→`TX_EMPTY`: load into an idle shifter with no new write.
- `TX_HELD`→`TX_HELD`: load together with a new write.
- Any state→`TX_OFF`: enable cleared.

The receive machine has two states:
- `RX_VACANT`: the receive register is free.
- `RX_HOLDING`: the receive register holds an unread byte.

Its transitions are:
- `RX_VACANT`→`RX_HOLDING`: byte captured.
- `RX_HOLDING`→`RX_VACANT`: the full flag is cleared by software with no capture in the same cycle.
- `RX_HOLDING`→`RX_HOLDING`: capture while full, which is an overrun.

Register map (byte wide, `bus_addr`):

| Address | Register | Access | Bits |
|---|---|---|---|
| 0 | control | read/write | 7 transmit IRQ enable, 6 receive IRQ enable, 5 transmit enable, 4 wait IRQ enable |
| 1 | transmit data | write; a read returns the last written byte | all |
| 2 | receive data | read-only | all |
| 3 | status | read; write-to-clear | 7 tx-empty, 6 rx-full, 5 overrun, 4 parity, 3 card error signal, 2 wait error |

Register reads are combinational.

Top module: `scard_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x80 (only tx-empty set) and all three interrupt outputs are low.
- R2: With transmit enable (control bit 5) at 1, a write to address 1 clears tx-empty (status bit 7). `tx_load` pulses with that byte on `tx_byte` only in a cycle where `tx_idle` is 1. After that clock edge tx-empty reads 1 again.
- R3: While transmit enable is 0, tx-empty reads 1 and `tx_load` stays low, including after writes to address 1. Clearing the enable discards a byte that has not been loaded.
- R4: `irq_txe` is high exactly when tx-empty and the transmit IRQ enable (control bit 7) are both 1.
- R5: A `rx_valid` strobe while rx-full (status bit 6) is 0 stores `rx_byte` into address 2 and sets rx-full.
- R6: A `rx_valid` strobe while rx-full is 1 sets overrun (status bit 5) and leaves the receive data unchanged.
- R7: `irq_rxf` is high exactly when rx-full and the receive IRQ enable (control bit 6) are both 1.
- R8: Strobes on `err_parity` and `err_signal` set status bits 4 and 3. `irq_err` is high when the receive IRQ enable is 1 and any of bits 5, 4 or 3 is 1; clearing those flags or the enable removes it.
- R9: `err_wait` sets status bit 2, which raises `irq_err` only through the wait IRQ enable (control bit 4), independent of the receive IRQ enable.
- R10: A status flag among bits 6..2 is cleared by reading it as 1 at address 3 and then writing 0 to it at address 3. Writing 1, or writing 0 without that prior read, leaves the flag unchanged.
- R11: When a hardware set of a flag and its software clear fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clears) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| tx_idle | input | 1 | Transmit shifter can accept a byte |
| tx_load | output | 1 | Byte handed to the transmit shifter this cycle |
| tx_byte | output | DW | Byte offered to the transmit shifter |
| rx_valid | input | 1 | Receive shifter completed a byte |
| rx_byte | input | DW | Completed received byte |
| err_parity | input | 1 | Parity error strobe |
| err_signal | input | 1 | Card error-signal strobe |
| err_wait | input | 1 | Wait-time error strobe |
| irq_txe | output | 1 | Transmit-empty interrupt request |
| irq_rxf | output | 1 | Receive-full interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
The assertions take for granted that the engine strobes last one cycle. They also assume a status read and a status write never share a cycle, and that `tx_idle` is a level the shifter keeps until it has taken a load. The stimulus raises at most one bus strobe per cycle. It holds `tx_idle` low through the table so held bytes stay visible, and raises it only in the directed transmit test. A capture and a status clear are placed in the same cycle only in the directed set-wins test.

// File: rtl/scard_pkg.sv
package scard_pkg;

    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        A_CTRL = 2'd0,
        A_TXD  = 2'd1,
        A_RXD  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    // control bit positions
    localparam int CB_TXIE = 7;
    localparam int CB_RXIE = 6;
    localparam int CB_TXEN = 5;
    localparam int CB_WTIE = 4;

    // status bit positions; bits SB_LO .. SB_LO+NFLAG-1 are clearable
    localparam int SB_TXE  = 7;
    localparam int SB_LO   = 2;
    localparam int NFLAG   = 5;
    localparam int FI_WTE  = 0;
    localparam int FI_ESG  = 1;
    localparam int FI_PAR  = 2;
    localparam int FI_OVR  = 3;
    localparam int FI_RXF  = 4;

    typedef enum logic [1:0] {
        TX_OFF   = 2'd0,
        TX_EMPTY = 2'd1,
        TX_HELD  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_VACANT  = 1'b0,
        RX_HOLDING = 1'b1
    } rx_state_e;

endpackage

// File: rtl/scard_tx_path.sv
module scard_tx_path
    import scard_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          wr_txd,
    input  logic [DW-1:0] wdata,
    input  logic          shifter_idle,
    output logic          load_pulse,
    output logic [DW-1:0] load_data,
    output logic          empty_flag
);

    tx_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_txd) begin
            data_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_OFF: begin
                if (tx_en) state_d = wr_txd ? TX_HELD : TX_EMPTY;
            end
            TX_EMPTY: begin
                if (!tx_en)      state_d = TX_OFF;
                else if (wr_txd) state_d = TX_HELD;
            end
            TX_HELD: begin
                if (!tx_en)            state_d = TX_OFF;
                else if (shifter_idle) state_d = wr_txd ? TX_HELD : TX_EMPTY;
            end
            default: state_d = TX_OFF;
        endcase
    end

    always_comb begin
        load_pulse = (state_q == TX_HELD) && tx_en && shifter_idle;
        load_data  = data_q;
        empty_flag = (state_q != TX_HELD) || !tx_en;
    end

endmodule

// File: rtl/scard_rx_path.sv
module scard_rx_path
    import scard_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic             err_par,
    input  logic             err_esg,
    input  logic             err_wait,
    input  logic             stat_rd,
    input  logic             stat_wr,
    input  logic [NFLAG-1:0] stat_wbits,
    output logic [DW-1:0]    rx_data,
    output logic [NFLAG-1:0] flags
);

    rx_state_e state_q, state_d;
    logic [NFLAG-1:0] arm_q;
    logic [NFLAG-1:0] clr;
    logic [NFLAG-1:0] hw_set;
    logic [NFLAG-1:0] flg_q;

    assign clr = {NFLAG{stat_wr}} & arm_q & ~stat_wbits;

    always_comb begin
        hw_set         = '0;
        hw_set[FI_WTE] = err_wait;
        hw_set[FI_ESG] = err_esg;
        hw_set[FI_PAR] = err_par;
        hw_set[FI_OVR] = rx_valid && (state_q == RX_HOLDING);
        hw_set[FI_RXF] = rx_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_VACANT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_VACANT: begin
                if (rx_valid) state_d = RX_HOLDING;
            end
            RX_HOLDING: begin
                if (clr[FI_RXF] && !rx_valid) state_d = RX_VACANT;
            end
            default: state_d = RX_VACANT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (rx_valid && state_q == RX_VACANT) begin
            rx_data <= rx_byte;
        end
    end

    // error and overrun flags: hardware set dominates the software clear
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        if (i == FI_RXF) begin : g_fsm
            assign flg_q[i] = (state_q == RX_HOLDING);
        end else begin : g_reg
            logic f_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    f_q <= 1'b0;
                end else begin
                    f_q <= hw_set[i] | (f_q & ~clr[i]);
                end
            end
            assign flg_q[i] = f_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= '0;
        end else if (stat_wr) begin
            arm_q <= '0;
        end else if (stat_rd) begin
            arm_q <= flg_q;
        end
    end

    assign flags = flg_q;

endmodule

// File: rtl/scard_irq_ctrl.sv
module scard_irq_ctrl
    import scard_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tx_idle,
    output logic          tx_load,
    output logic [DW-1:0] tx_byte,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          err_parity,
    input  logic          err_signal,
    input  logic          err_wait,
    output logic          irq_txe,
    output logic          irq_rxf,
    output logic          irq_err
);

    reg_addr_e addr;
    logic ctl_txie, ctl_rxie, ctl_txen, ctl_wtie;
    logic txd_wr, stat_wr, stat_rd, ctl_wr;
    logic f_txe;
    logic [NFLAG-1:0] rflags;
    logic [DW-1:0] rxd_q;
    logic [DW-1:0] stat_word, ctrl_word;

    assign addr    = reg_addr_e'(bus_addr);
    assign ctl_wr  = bus_wr && addr == A_CTRL;
    assign txd_wr  = bus_wr && addr == A_TXD;
    assign stat_wr = bus_wr && addr == A_STAT;
    assign stat_rd = bus_rd && addr == A_STAT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_txie <= 1'b0;
            ctl_rxie <= 1'b0;
            ctl_txen <= 1'b0;
            ctl_wtie <= 1'b0;
        end else if (ctl_wr) begin
            ctl_txie <= bus_wdata[CB_TXIE];
            ctl_rxie <= bus_wdata[CB_RXIE];
            ctl_txen <= bus_wdata[CB_TXEN];
            ctl_wtie <= bus_wdata[CB_WTIE];
        end
    end

    scard_tx_path #(.DW(DW)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (ctl_txen),
        .wr_txd       (txd_wr),
        .wdata        (bus_wdata),
        .shifter_idle (tx_idle),
        .load_pulse   (tx_load),
        .load_data    (tx_byte),
        .empty_flag   (f_txe)
    );

    scard_rx_path #(.DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .err_par    (err_parity),
        .err_esg    (err_signal),
        .err_wait   (err_wait),
        .stat_rd    (stat_rd),
        .stat_wr    (stat_wr),
        .stat_wbits (bus_wdata[SB_LO +: NFLAG]),
        .rx_data    (rxd_q),
        .flags      (rflags)
    );

    always_comb begin
        stat_word                 = '0;
        stat_word[SB_TXE]         = f_txe;
        stat_word[SB_LO +: NFLAG] = rflags;
        ctrl_word                 = '0;
        ctrl_word[CB_TXIE]        = ctl_txie;
        ctrl_word[CB_RXIE]        = ctl_rxie;
        ctrl_word[CB_TXEN]        = ctl_txen;
        ctrl_word[CB_WTIE]        = ctl_wtie;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  bus_rdata = ctrl_word;
            A_TXD:   bus_rdata = tx_byte;
            A_RXD:   bus_rdata = rxd_q;
            A_STAT:  bus_rdata = stat_word;
            default: bus_rdata = '0;
        endcase
    end

    always_comb begin
        irq_txe = f_txe && ctl_txie;
        irq_rxf = rflags[FI_RXF] && ctl_rxie;
        irq_err = (ctl_rxie && (rflags[FI_OVR] || rflags[FI_PAR] || rflags[FI_ESG]))
               || (ctl_wtie && rflags[FI_WTE]);
    end

endmodule

// File: rtl/scard_irq_ctrl_chk.sv
module scard_irq_ctrl_chk
    import scard_pkg::*;
#(
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_txen,
    input logic             ctl_rxie,
    input logic             ctl_wtie,
    input logic             txd_wr,
    input logic             tx_idle,
    input logic             tx_load,
    input logic             rx_valid,
    input logic [DW-1:0]    rx_byte,
    input logic [DW-1:0]    rxd_q,
    input logic             f_txe,
    input logic [NFLAG-1:0] rflags,
    input logic             irq_rxf,
    input logic             irq_err
);

    AST_TXE_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_txen |-> f_txe && !tx_load); // R3
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> tx_idle); // R2
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load && !txd_wr |=> f_txe); // R2
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rflags[FI_RXF] |=> rflags[FI_RXF] && rxd_q == $past(rx_byte)); // R5
    AST_OVERRUN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rflags[FI_RXF] |=> rflags[FI_OVR] && $stable(rxd_q)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rflags[FI_RXF]); // R11
    AST_RXF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxf |-> rflags[FI_RXF]); // R7
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> ctl_rxie || ctl_wtie); // R8
    AST_WAIT_OWN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err && !ctl_rxie |-> ctl_wtie && rflags[FI_WTE]); // R9

endmodule

bind scard_irq_ctrl scard_irq_ctrl_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_txen (ctl_txen),
    .ctl_rxie (ctl_rxie),
    .ctl_wtie (ctl_wtie),
    .txd_wr   (txd_wr),
    .tx_idle  (tx_idle),
    .tx_load  (tx_load),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rxd_q    (rxd_q),
    .f_txe    (f_txe),
    .rflags   (rflags),
    .irq_rxf  (irq_rxf),
    .irq_err  (irq_err)
);

// File: tb/scard_irq_ctrl_tb.sv
module scard_irq_ctrl_tb;

    localparam int DW = 8;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RX = 3'd2,
                           OP_PAR = 3'd3, OP_ESG = 3'd4, OP_WT = 3'd5;
    localparam logic [1:0] CTRL = 2'd0, TXD = 2'd1, RXD = 2'd2, STAT = 2'd3;
    // vector: {op, addr, data, expected read, expected irq {txe,rxf,err}, requirement number}
    localparam int NV = 47;
    localparam logic [27:0] VEC [NV] = '{
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd1},   // R1 reset status
        {OP_RD,  CTRL, 8'h00, 8'h00, 3'b000, 4'd1},   // R1 reset control
        {OP_WR,  CTRL, 8'h80, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b100, 4'd4},   // R4 txe irq
        {OP_WR,  TXD,  8'h5A, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b100, 4'd3},   // R3 pinned
        {OP_WR,  CTRL, 8'hA0, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b100, 4'd2},
        {OP_WR,  TXD,  8'hC3, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h00, 3'b000, 4'd2},   // R2 held byte
        {OP_WR,  CTRL, 8'h20, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h00, 3'b000, 4'd4},   // R4
        {OP_WR,  CTRL, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd3},   // R3 enable cleared
        {OP_WR,  CTRL, 8'h40, 8'h00, 3'b000, 4'd0},
        {OP_RX,  RXD,  8'h3C, 8'h00, 3'b000, 4'd0},
        {OP_RD,  RXD,  8'h00, 8'h3C, 3'b010, 4'd5},   // R5 R7
        {OP_RD,  STAT, 8'h00, 8'hC0, 3'b010, 4'd7},
        {OP_WR,  STAT, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd10},  // R10 clear
        {OP_RX,  RXD,  8'h11, 8'h00, 3'b000, 4'd0},
        {OP_RX,  RXD,  8'h22, 8'h00, 3'b000, 4'd0},
        {OP_RD,  RXD,  8'h00, 8'h11, 3'b011, 4'd6},   // R6 data kept
        {OP_RD,  STAT, 8'h00, 8'hE0, 3'b011, 4'd6},
        {OP_WR,  STAT, 8'hDF, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'hC0, 3'b010, 4'd10},  // R10 write 1 keeps
        {OP_WR,  STAT, 8'hBF, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd10},
        {OP_PAR, RXD,  8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h90, 3'b001, 4'd8},   // R8 parity
        {OP_WR,  CTRL, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h90, 3'b000, 4'd8},   // R8 enable off
        {OP_WR,  STAT, 8'hFF, 8'h00, 3'b000, 4'd0},
        {OP_WR,  STAT, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h90, 3'b000, 4'd10},  // R10 no prior read
        {OP_WR,  STAT, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd10},
        {OP_ESG, RXD,  8'h00, 8'h00, 3'b000, 4'd0},
        {OP_WR,  CTRL, 8'h40, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h88, 3'b001, 4'd8},   // R8 error signal
        {OP_WR,  STAT, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_WT,  RXD,  8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h84, 3'b000, 4'd9},   // R9 rx enable alone
        {OP_WR,  CTRL, 8'h10, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h84, 3'b001, 4'd9},   // R9 wait enable
        {OP_WR,  STAT, 8'h00, 8'h00, 3'b000, 4'd0},
        {OP_RD,  STAT, 8'h00, 8'h80, 3'b000, 4'd9}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0, bus_rdata;
    logic tx_idle = 1'b0, tx_load;
    logic [DW-1:0] tx_byte;
    logic rx_valid = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic err_parity = 1'b0, err_signal = 1'b0, err_wait = 1'b0;
    logic irq_txe, irq_rxf, irq_err;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    scard_irq_ctrl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_idle(tx_idle), .tx_load(tx_load), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .err_parity(err_parity),
        .err_signal(err_signal), .err_wait(err_wait),
        .irq_txe(irq_txe), .irq_rxf(irq_rxf), .irq_err(irq_err)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_drives();
        bus_wr = 0; bus_rd = 0; rx_valid = 0;
        err_parity = 0; err_signal = 0; err_wait = 0;
    endtask

    task automatic apply(input logic [2:0] op, input logic [1:0] addr, input logic [7:0] data,
                         input logic [7:0] exp, input logic [2:0] irqx, input string req);
        @(negedge clk);
        clear_drives();
        bus_addr = addr;
        unique case (op)
            OP_WR:  begin bus_wr = 1; bus_wdata = data; end
            OP_RD:  bus_rd = 1;
            OP_RX:  begin rx_valid = 1; rx_byte = data; end
            OP_PAR: err_parity = 1;
            OP_ESG: err_signal = 1;
            OP_WT:  err_wait = 1;
            default: ;
        endcase
        #1;
        if (op == OP_RD) begin
            check({8'h00, bus_rdata}, {8'h00, exp}, {req, " read"});
            check({13'h0, irq_txe, irq_rxf, irq_err}, {13'h0, irqx}, {req, " irq"});
        end
        @(posedge clk);
        #1;
        clear_drives();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check({13'h0, irq_txe, irq_rxf, irq_err}, 16'h0, "R1 irq at reset");

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27:25], VEC[i][24:23], VEC[i][22:15], VEC[i][14:7],
                  VEC[i][6:4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // R2: byte held until shifter idle, then loaded and tx-empty returns
        apply(OP_WR, CTRL, 8'h20, 8'h00, 3'b000, "R2");
        apply(OP_WR, TXD,  8'hA5, 8'h00, 3'b000, "R2");
        @(negedge clk);
        check({15'h0, tx_load}, 16'h0, "R2 no load while busy");
        tx_idle = 1'b1;
        #1;
        check({7'h0, tx_load, tx_byte}, {7'h0, 1'b1, 8'hA5}, "R2 load when idle");
        @(posedge clk);
        #1;
        check({15'h0, tx_load}, 16'h0, "R2 single load");
        apply(OP_RD, STAT, 8'h00, 8'h80, 3'b000, "R2 empty after load");

        // R3: disabled transmitter never loads
        apply(OP_WR, CTRL, 8'h00, 8'h00, 3'b000, "R3");
        apply(OP_WR, TXD,  8'h66, 8'h00, 3'b000, "R3");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check({15'h0, tx_load}, 16'h0, "R3 no load when disabled");
        end
        tx_idle = 1'b0;

        // R11: capture and clear of rx-full in the same cycle
        apply(OP_RX, RXD, 8'h77, 8'h00, 3'b000, "R11");
        apply(OP_RD, STAT, 8'h00, 8'hC0, 3'b000, "R11 armed");
        @(negedge clk);
        clear_drives();
        bus_addr = STAT; bus_wr = 1; bus_wdata = 8'h00;
        rx_valid = 1; rx_byte = 8'h99;
        @(posedge clk);
        #1 clear_drives();
        apply(OP_RD, STAT, 8'h00, 8'hE0, 3'b000, "R11 set wins");
        apply(OP_RD, RXD,  8'h00, 8'h77, 3'b000, "R6 data kept");

        // R1: reset mid-run restores defaults
        apply(OP_WR, CTRL, 8'hF0, 8'h00, 3'b000, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        bus_addr = CTRL;
        #1 check({8'h00, bus_rdata}, 16'h0000, "R1 control after reset");
        bus_addr = STAT;
        #1 check({8'h00, bus_rdata}, 16'h0080, "R1 status after reset");
        check({13'h0, irq_txe, irq_rxf, irq_err}, 16'h0, "R1 irq after reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule